// File: doc/BRIEF.md
# Carry-Pipelined Phase Accumulator

This block is the phase register of a direct digital synthesizer. Every clock it adds a frequency control word to a running phase. The phase wraps modulo 2^W, where W is the phase width. The adder is split into `SLICES` slices of `SLICE_W` bits each. The carry between neighbouring slices passes through a flop, so the longest combinational path in a cycle is a single slice.

To make this work, slice k sees its part of the control word after k cycles of input skew. Its accumulated bits then pass through `SLICES-1-k` cycles of output deskew. As a result, every bit of the phase output describes the same instant. A one-bit slice is a full adder. A wider slice forms its carries by carry lookahead, with each carry fully expanded in terms of the slice's carry in.

The parameters trade latency against logic depth:

| Configuration | Latency | Logic per cycle |
|---|---|---|
| 8 slices of 1 bit (default) | 7 cycles | one full adder |
| 2 slices of 4 bits | 1 cycle | one 4-bit lookahead adder |
| 1 slice of 8 bits | 0 cycles | one 8-bit lookahead adder |

Top module: `dds_phase_pipe`

## Requirements
- R1: The phase is accumulated modulo 2^W. The carry into bit 0 is zero and the carry out of the top bit is dropped, so a control word of 1 steps the phase 0,1,...,255,0 in the default configuration.
- R2: In the default configuration (SLICE_W=1, SLICES=8), the output after clock edge e (counted from reset release) equals the ideal accumulator after edge e-7. Before edge 7 the output is 0.
- R3: With SLICE_W=4 and SLICES=2, the output after edge e equals the ideal accumulator after edge e-1.
- R4: With SLICE_W=8 and SLICES=1, the output after edge e equals the ideal accumulator after edge e, with no extra delay.
- R5: While rst_n is low, the output is 0 at once, without waiting for a clock edge. After release, accumulation restarts from phase 0.
- R6: A control word that changes on every cycle is tracked without error. A word of 0 leaves the phase unchanged once that word reaches the output.
- R7: A control word of all ones (255) makes the phase fall by 1 per cycle, wrapping from 0 to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all flops |
| rst_n | input | 1 | Active-low asynchronous reset; clears every flop to 0 |
| fcw_i | input | SLICE_W*SLICES | Frequency control word added each cycle |
| phase_o | output | SLICE_W*SLICES | Aligned accumulated phase |

## Verification
The ideal accumulator takes the control word present at each rising edge. After edge e it holds A(e). The phase output after that same edge is due to equal A(e-(SLICES-1)): that is 7 edges later for the default build, 1 for the 4x2 build and 0 for the 8x1 build.

The bench drives inputs and samples outputs at the falling edge. It keeps a ring of past A values and compares each build against the entry its own latency selects; entries from before reset release count as 0. The asynchronous clear is checked 1 ns after rst_n falls, before any further clock edge.

// File: rtl/dds_phase_pkg.sv
package dds_phase_pkg;
    localparam int DEF_SLICE_W = 1;
    localparam int DEF_SLICES  = 8;

    typedef enum logic {
        ADD_FULL      = 1'b0,
        ADD_LOOKAHEAD = 1'b1
    } add_kind_e;

    function automatic add_kind_e pick_adder(input int width);
        return (width == 1) ? ADD_FULL : ADD_LOOKAHEAD;
    endfunction
endpackage

// File: rtl/dpp_delay.sv
module dpp_delay #(
    parameter int W     = 1,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/dpp_slice_add.sv
module dpp_slice_add
    import dds_phase_pkg::*;
#(
    parameter int W = 1
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    localparam add_kind_e KIND = pick_adder(W);

    generate
        if (KIND == ADD_FULL) begin : g_full
            // single full adder: sum is parity, carry is majority
            assign sum_o  = a_i ^ b_i ^ cin_i;
            assign cout_o = (a_i & b_i) | (b_i & cin_i) | (cin_i & a_i);
        end else begin : g_cla
            logic [W-1:0] gen_b;
            logic [W-1:0] prp_b;
            logic [W:0]   cy;

            assign gen_b = a_i & b_i;
            assign prp_b = a_i ^ b_i;

            // each carry written as a flat sum of products over the
            // generates below it and the slice carry in
            always_comb begin
                logic term;
                logic run;
                cy[0] = cin_i;
                for (int i = 0; i < W; i++) begin
                    term = gen_b[i];
                    run  = prp_b[i];
                    for (int j = i - 1; j >= 0; j--) begin
                        term = term | (run & gen_b[j]);
                        run  = run & prp_b[j];
                    end
                    cy[i+1] = term | (run & cin_i);
                end
            end

            assign sum_o  = prp_b ^ cy[W-1:0];
            assign cout_o = cy[W];
        end
    endgenerate
endmodule

// File: rtl/dds_phase_pipe.sv
module dds_phase_pipe
    import dds_phase_pkg::*;
#(
    parameter int SLICE_W = DEF_SLICE_W,
    parameter int SLICES  = DEF_SLICES
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SLICE_W*SLICES-1:0]  fcw_i,
    output logic [SLICE_W*SLICES-1:0]  phase_o
);
    localparam int PHASE_W = SLICE_W * SLICES;
    localparam int LAST    = SLICES - 1;

    logic [SLICES-1:0] carry_in;
    logic              msb_carry_unused;

    assign carry_in[0] = 1'b0;

    generate
        for (genvar k = 0; k < SLICES; k++) begin : g_slice
            localparam int LO = k * SLICE_W;

            logic [SLICE_W-1:0] word_k;
            logic [SLICE_W-1:0] acc_q;
            logic [SLICE_W-1:0] sum_k;
            logic               cout_k;

            // input skew: k cycles so the word meets its rippled carry
            if (k == 0) begin : g_noskew
                assign word_k = fcw_i[LO +: SLICE_W];
            end else begin : g_skew
                dpp_delay #(.W(SLICE_W), .DEPTH(k)) u_skew (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .d_i   (fcw_i[LO +: SLICE_W]),
                    .q_o   (word_k)
                );
            end

            dpp_slice_add #(.W(SLICE_W)) u_add (
                .a_i    (acc_q),
                .b_i    (word_k),
                .cin_i  (carry_in[k]),
                .sum_o  (sum_k),
                .cout_o (cout_k)
            );

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) acc_q <= '0;
                else        acc_q <= sum_k;
            end

            // registered carry to the next slice; top carry is dropped
            if (k < LAST) begin : g_carry
                logic carry_q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) carry_q <= 1'b0;
                    else        carry_q <= cout_k;
                end
                assign carry_in[k+1] = carry_q;
            end else begin : g_msb
                assign msb_carry_unused = cout_k;
            end

            // output deskew: LAST-k cycles so all slices line up
            if (k == LAST) begin : g_nodeskew
                assign phase_o[LO +: SLICE_W] = acc_q;
            end else begin : g_deskew
                dpp_delay #(.W(SLICE_W), .DEPTH(LAST - k)) u_deskew (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .d_i   (acc_q),
                    .q_o   (phase_o[LO +: SLICE_W])
                );
            end
        end
    endgenerate

    if (PHASE_W < 1) begin : g_bad_cfg
        initial $error("phase width must be positive");
    end
endmodule

// File: rtl/dds_phase_pipe_chk.sv
module dds_phase_pipe_chk #(
    parameter int SLICE_W = 1,
    parameter int SLICES  = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [SLICE_W*SLICES-1:0] fcw_i,
    input logic [SLICE_W*SLICES-1:0] phase_o
);
    localparam int PW = SLICE_W * SLICES;

    // edges seen since reset release, saturating
    logic [3:0] seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              seen <= '0;
        else if (seen != 4'hF)   seen <= seen + 4'd1;
    end

    // R5: output held at zero whenever reset is asserted
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_clear_r5: assert (phase_o == '0)
                else $error("phase not cleared in reset");
        end
    end

    // R2: nothing emerges before the pipeline has filled
    p_fill_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(seen) < SLICES) |-> (phase_o == '0));

    // R1: each output step equals the word applied SLICES edges earlier, mod 2^PW
    p_step_mod_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(seen) >= SLICES) |->
        (PW'(phase_o - $past(phase_o)) == $past(fcw_i, SLICES)));

    // R6: a zero word reaching the output leaves the phase unchanged
    p_zero_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(seen) >= SLICES) && ($past(fcw_i, SLICES) == '0)) |->
        $stable(phase_o));
endmodule

bind dds_phase_pipe dds_phase_pipe_chk #(.SLICE_W(SLICE_W), .SLICES(SLICES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fcw_i   (fcw_i),
    .phase_o (phase_o)
);

// File: tb/tb_dds_phase_pipe.sv
`timescale 1ns/1ps
module tb_dds_phase_pipe;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] fcw = '0;
    logic [7:0] ph_a, ph_b, ph_c;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    int         edges;
    logic [7:0] model;
    logic [7:0] ring [16];
    string      tag_a;

    always #2.5 clk = ~clk;

    dds_phase_pipe dut (
        .clk(clk), .rst_n(rst_n), .fcw_i(fcw), .phase_o(ph_a));
    dds_phase_pipe #(.SLICE_W(4), .SLICES(2)) dut_cla (
        .clk(clk), .rst_n(rst_n), .fcw_i(fcw), .phase_o(ph_b));
    dds_phase_pipe #(.SLICE_W(8), .SLICES(1)) dut_flat (
        .clk(clk), .rst_n(rst_n), .fcw_i(fcw), .phase_o(ph_c));

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s edge=%0d got=%0h exp=%0h", tag, edges, got, exp);
        end
    endtask

    function automatic logic [7:0] expect_at(input int lat);
        return (edges >= lat) ? ring[(edges - lat) % 16] : 8'h00;
    endfunction

    // drive at falling edge, advance one clock, compare at next falling edge
    task automatic step(input logic [7:0] f);
        fcw = f;
        @(posedge clk);
        edges++;
        model = model + f;
        ring[edges % 16] = model;
        @(negedge clk);
        check(tag_a, ph_a, expect_at(7));
        check("R3", ph_b, expect_at(1));
        check("R4", ph_c, expect_at(0));
    endtask

    task automatic restart();
        edges = 0;
        model = '0;
        for (int i = 0; i < 16; i++) ring[i] = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        tag_a = "R2";
        repeat (3) @(negedge clk);
        check("R5", ph_a, 8'h00);
        check("R5", ph_b, 8'h00);
        check("R5", ph_c, 8'h00);
        restart();

        // R1: unit word, two full wraps
        tag_a = "R1";
        for (int i = 0; i < 520; i++) step(8'h01);

        // R2: sweep every word value, three cycles each
        tag_a = "R2";
        for (int v = 0; v < 256; v++) repeat (3) step(8'(v));

        // R7: all-ones word counts down through zero
        tag_a = "R7";
        for (int i = 0; i < 300; i++) step(8'hFF);

        // R6: zero word holds, then a new word on every cycle
        tag_a = "R6";
        for (int i = 0; i < 20; i++) step(8'h00);
        for (int i = 0; i < 2000; i++) step(8'($urandom));

        // R5: asynchronous clear in the middle of a run
        for (int i = 0; i < 5; i++) step(8'h37);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R5", ph_a, 8'h00);
        check("R5", ph_b, 8'h00);
        check("R5", ph_c, 8'h00);
        repeat (2) @(negedge clk);
        restart();
        tag_a = "R5";
        for (int i = 0; i < 30; i++) step(8'($urandom));

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired edge=%0d got=hung exp=done", edges);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule